// File: doc/BRIEF.md
# Latched Fault and Supply Supervisor for an H-Bridge Driver

This block gathers the protection flags of a brushed-motor H-bridge (output short, overcurrent and overheat) together with the supply comparator levels. It drives an active-low fault indication and a shutdown command that the bridge decoder uses to force all four switches off.

A detector event sets a fault latch. Only a power-on reset of the logic supply clears that latch. The power-on reset comes either from the hardware reset pin or from the logic-supply undervoltage state. That state is built from two comparator outputs with hysteresis: it sets when the supply falls below about 3.8 V and releases once the supply rises above about 4 V.

A motor-supply undervoltage (below about 8.8 V) holds the bridge off for as long as it lasts, but never sets the latch. The overcurrent and short flags must stay high for a configurable number of samples before they count. A short-flag sample counts only once the bridge enable has been high for a minimum time (about 16 µs), because short detection is unreliable during narrow enable pulses.

Top module: `fault_supervisor`

## Requirements
- R1: While `rstN` is low, `faultN` is 1 and `bridgeOff` is 1. The fault latch is clear and the logic-supply undervoltage state is set.
- R2: The logic-supply undervoltage state behaves as follows at each clock edge:
  - It is set when `vddBelowLow` is sampled 1.
  - It is cleared when `vddBelowLow` is 0 and `vddBelowHigh` is 0.
  - It holds otherwise.
  - While it is set, `bridgeOff` is 1.
- R3: At an edge where the undervoltage state is already set, the fault latch and both sample filters are cleared. `faultN` is therefore 1 from the next cycle on, and no event counts while the state stays set.
- R4: `vmotLow` = 1 drives `bridgeOff` to 1 in the same cycle. It never sets the fault latch, so `bridgeOff` returns to its other terms once `vmotLow` is 0.
- R5: The fault latch sets at the edge that samples the FILT_CYC-th consecutive 1 on `ocDet`. A shorter run has no effect.
- R6: A `shortDet` sample counts only when two conditions hold: `enable` is 1 at that edge, and `enable` was also 1 on each of the EN_QUAL_CYC preceding edges. The latch sets at the edge of the FILT_CYC-th consecutive counted sample. A sample that does not count restarts the run.
- R7: `heatDet` sampled 1 sets the fault latch at that same edge.
- R8: Once set, the fault latch stays set whatever the detector, enable and motor-supply inputs do, until R1 or R3 applies.
- R9: `faultN` is the inverse of the fault latch. `bridgeOff` is 1 exactly when any of the following is set: the fault latch, the undervoltage state, or `vmotLow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| vddBelowLow | input | 1 | Logic supply below the lower (falling) threshold |
| vddBelowHigh | input | 1 | Logic supply below the upper (rising) threshold |
| vmotLow | input | 1 | Motor supply below its undervoltage level |
| enable | input | 1 | Bridge enable (DC or PWM) |
| shortDet | input | 1 | Output short-circuit detector flag |
| ocDet | input | 1 | Overcurrent comparator flag |
| heatDet | input | 1 | Substrate overheat flag |
| faultN | output | 1 | Active-low latched fault indication |
| bridgeOff | output | 1 | Command to turn all bridge switches off |

## Verification
The hardest condition to reach from the ports is the boundary of short-circuit qualification. A short flag has to be held across the exact edge at which the enable history first becomes long enough, and a single enable-low sample must be shown to restart both the enable history and the short run.

The stimulus covers this in three steps:
- It raises the short flag inside an enable pulse that is too short.
- It holds enable long enough and then applies a short of exactly the filter length.
- It drops enable for one cycle in the middle of a short run.

A behavioural model compares both outputs on every clock, so an off-by-one edge in any of these cases shows up at once.

// File: rtl/fault_supervisor_pkg.sv
package fault_supervisor_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clrFilters;
  } ctrlStrobes_t;

  // qualified events from datapath to control
  typedef struct packed {
    logic scHit;
    logic ocHit;
    logic ohHit;
  } detEvents_t;
endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import fault_supervisor_pkg::*;
#(
  parameter int FILT_CYC    = 4,
  parameter int EN_QUAL_CYC = 3200
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         enable,
  input  logic         shortDet,
  input  logic         ocDet,
  input  logic         heatDet,
  output detEvents_t   events
);
  localparam int FW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam int EW = $clog2(EN_QUAL_CYC + 1);
  localparam int NCH = 2;

  logic [EW-1:0] enRun;
  logic          enQual;
  logic [NCH-1:0] chIn;
  logic [NCH-1:0] chHit;

  assign enQual = (enRun == EW'(EN_QUAL_CYC));

  // run length of enable-high samples, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enRun <= '0;
    else if (strobes.clrFilters || !enable) enRun <= '0;
    else if (!enQual) enRun <= enRun + 1'b1;
  end

  assign chIn[0] = ocDet;
  assign chIn[1] = shortDet && enable && enQual;

  for (genvar g = 0; g < NCH; g++) begin : gFilt
    logic [FW-1:0] run;
    logic          full;
    assign full     = (run == FW'(FILT_CYC - 1));
    assign chHit[g] = chIn[g] && full;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) run <= '0;
      else if (strobes.clrFilters || !chIn[g]) run <= '0;
      else if (!full) run <= run + 1'b1;
    end
  end

  assign events.ocHit = chHit[0];
  assign events.scHit = chHit[1];
  assign events.ohHit = heatDet;
endmodule

// File: rtl/supv_control.sv
module supv_control
  import fault_supervisor_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         vddBelowLow,
  input  logic         vddBelowHigh,
  input  logic         vmotLow,
  input  detEvents_t   events,
  output ctrlStrobes_t strobes,
  output logic         faultN,
  output logic         bridgeOff
);
  logic vddUnder;
  logic faultLat;

  // hysteresis on the two logic-supply comparator levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vddUnder <= 1'b1;
    else if (vddBelowLow) vddUnder <= 1'b1;
    else if (!vddBelowHigh) vddUnder <= 1'b0;
  end

  // fault latch, cleared only by power-on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultLat <= 1'b0;
    else if (vddUnder) faultLat <= 1'b0;
    else if (events.scHit || events.ocHit || events.ohHit) faultLat <= 1'b1;
  end

  assign strobes.clrFilters = vddUnder;
  assign faultN    = ~faultLat;
  assign bridgeOff = faultLat | vddUnder | vmotLow;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fault_supervisor_pkg::*;
#(
  parameter int FILT_CYC    = 4,
  parameter int EN_QUAL_CYC = 3200
) (
  input  logic clk,
  input  logic rstN,
  input  logic vddBelowLow,
  input  logic vddBelowHigh,
  input  logic vmotLow,
  input  logic enable,
  input  logic shortDet,
  input  logic ocDet,
  input  logic heatDet,
  output logic faultN,
  output logic bridgeOff
);
  ctrlStrobes_t strobes;
  detEvents_t   events;

  supv_datapath #(.FILT_CYC(FILT_CYC), .EN_QUAL_CYC(EN_QUAL_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .enable(enable),
    .shortDet(shortDet), .ocDet(ocDet), .heatDet(heatDet), .events(events)
  );

  supv_control u_ctl (
    .clk(clk), .rstN(rstN), .vddBelowLow(vddBelowLow),
    .vddBelowHigh(vddBelowHigh), .vmotLow(vmotLow), .events(events),
    .strobes(strobes), .faultN(faultN), .bridgeOff(bridgeOff)
  );
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
  input logic clk,
  input logic rstN,
  input logic vddBelowLow,
  input logic vmotLow,
  input logic heatDet,
  input logic vddUnder,
  input logic faultN,
  input logic bridgeOff
);
  // R1: reset state
  always @(negedge clk)
    if (!rstN) a_r1_reset_state: assert (faultN && bridgeOff);

  a_r2_uv_sets_off: assert property (@(posedge clk) disable iff (!rstN)
    vddBelowLow |=> bridgeOff);

  a_r3_uv_clears_latch: assert property (@(posedge clk) disable iff (!rstN)
    vddUnder |=> faultN);

  a_r4_motor_low_off: assert property (@(posedge clk) disable iff (!rstN)
    vmotLow |-> bridgeOff);

  a_r7_heat_latches: assert property (@(posedge clk) disable iff (!rstN)
    (heatDet && !vddUnder) |=> !faultN);

  a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!faultN && !vddUnder) |=> !faultN);

  a_r9_fault_forces_off: assert property (@(posedge clk) disable iff (!rstN)
    !faultN |-> bridgeOff);
endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
  .clk(clk), .rstN(rstN), .vddBelowLow(vddBelowLow), .vmotLow(vmotLow),
  .heatDet(heatDet), .vddUnder(u_ctl.vddUnder), .faultN(faultN),
  .bridgeOff(bridgeOff)
);

// File: tb/fault_supervisor_bench.sv
`timescale 1ns/1ps
module fault_supervisor_bench;
  localparam int F = 3;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vddBelowLow = 1'b1, vddBelowHigh = 1'b1, vmotLow = 1'b0;
  logic enable = 1'b0, shortDet = 1'b0, ocDet = 1'b0, heatDet = 1'b0;
  logic faultN, bridgeOff;

  int checks = 0, fails = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  int mLatch = 0, mUnder = 1, ocRun = 0, scRun = 0, enRun = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(.FILT_CYC(F), .EN_QUAL_CYC(Q)) u_fault_supervisor (
    .clk(clk), .rstN(rstN), .vddBelowLow(vddBelowLow),
    .vddBelowHigh(vddBelowHigh), .vmotLow(vmotLow), .enable(enable),
    .shortDet(shortDet), .ocDet(ocDet), .heatDet(heatDet),
    .faultN(faultN), .bridgeOff(bridgeOff)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLatch = 0; mUnder = 1; ocRun = 0; scRun = 0; enRun = 0;
    end else begin
      bit scOk, hit;
      scOk = shortDet && enable && (enRun >= Q);
      hit = heatDet || (ocDet && ocRun >= F - 1) || (scOk && scRun >= F - 1);
      if (mUnder != 0) begin
        mLatch = 0; ocRun = 0; scRun = 0; enRun = 0;
      end else begin
        if (hit) mLatch = 1;
        ocRun = ocDet ? ocRun + 1 : 0;
        scRun = scOk ? scRun + 1 : 0;
        enRun = enable ? enRun + 1 : 0;
      end
      if (vddBelowLow) mUnder = 1;
      else if (!vddBelowHigh) mUnder = 0;
    end
  end

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // R9: per-clock comparison against the model
  always @(negedge clk) if (!done) begin
    chk({curReq, "/R9 faultN"}, faultN, (mLatch == 0));
    chk({curReq, "/R9 bridgeOff"}, bridgeOff,
        (mLatch != 0) || (mUnder != 0) || vmotLow);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic porCycle();
    vddBelowLow = 1; vddBelowHigh = 1; step(1);
    vddBelowLow = 0; step(1);
    vddBelowHigh = 0; step(1);
  endtask

  initial begin
    step(3);
    chk("R1 faultN", faultN, 1'b1);
    chk("R1 bridgeOff", bridgeOff, 1'b1);
    rstN = 1; step(1);
    curReq = "R2";
    vddBelowLow = 0; step(3);
    chk("R2 hold between thresholds", bridgeOff, 1'b1);
    vddBelowHigh = 0; step(1);
    chk("R2 release above upper", bridgeOff, 1'b0);
    vddBelowHigh = 1; step(2);
    chk("R2 stays released", bridgeOff, 1'b0);
    vddBelowHigh = 0;
    curReq = "R4";
    vmotLow = 1; #0.5;
    chk("R4 motor low same cycle", bridgeOff, 1'b1);
    step(3);
    vmotLow = 0; #0.5;
    chk("R4 no latch", bridgeOff, 1'b0);
    chk("R4 fault clear", faultN, 1'b1);
    curReq = "R5";
    ocDet = 1; step(F - 1); ocDet = 0; step(3);
    chk("R5 short run ignored", faultN, 1'b1);
    ocDet = 1; step(F);
    chk("R5 latched at run end", faultN, 1'b0);
    ocDet = 0;
    curReq = "R8";
    vmotLow = 1; enable = 1; step(4); vmotLow = 0; enable = 0; step(4);
    chk("R8 latch holds", faultN, 1'b0);
    chk("R8 bridge off", bridgeOff, 1'b1);
    curReq = "R3";
    porCycle();
    chk("R3 cleared by undervoltage", faultN, 1'b1);
    vddBelowLow = 1; step(1); vddBelowLow = 0; vddBelowHigh = 1;
    heatDet = 1; step(2); heatDet = 0;
    chk("R3 no event while under", faultN, 1'b1);
    vddBelowHigh = 0; step(2);
    chk("R3 bridge back on", bridgeOff, 1'b0);
    curReq = "R6";
    enable = 1; step(1); shortDet = 1; step(Q - 3);
    enable = 0; shortDet = 0; step(2);
    chk("R6 short in narrow pulse ignored", faultN, 1'b1);
    enable = 1; step(Q + 2);
    shortDet = 1; step(F - 1); enable = 0; step(1); enable = 1; step(F - 1);
    shortDet = 0; step(2);
    chk("R6 enable gap restarts", faultN, 1'b1);
    step(Q); shortDet = 1; step(F - 1);
    chk("R6 one short of length", faultN, 1'b1);
    step(1);
    chk("R6 qualified short latched", faultN, 1'b0);
    shortDet = 0; enable = 0;
    porCycle();
    curReq = "R7";
    heatDet = 1; step(1); heatDet = 0;
    chk("R7 overheat one sample", faultN, 1'b0);
    step(3);
    curReq = "R1";
    rstN = 0; step(1);
    chk("R1 reset clears fault", faultN, 1'b1);
    chk("R1 reset bridge off", bridgeOff, 1'b1);
    rstN = 1; porCycle(); step(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule